// File: doc/BRIEF.md
# UART interrupt identification and priority

This block produces the single interrupt request line and the interrupt identification byte of a 16550-style serial controller. It holds the four-bit interrupt enable register. Each cycle it samples the line-status byte, the modem-status byte, the receive FIFO fill level and trigger level, the character-timeout flag and the transmit-holding-empty flag. From these it picks the most urgent pending cause by a fixed five-level priority.

The transmit-empty cause is not a plain level. It is a sticky pending flag with three rules:
- It is set when the holding register becomes empty.
- It is consumed when software reads the identification byte while that byte shows transmit-empty.
- It is resampled whenever software changes the transmit-empty enable bit.

The register decode around the block and the FIFO storage are outside it. The surrounding logic pulses `ier_we` for a write to the enable register and `id_read` for a read of the identification byte.

Top module: `uart_irq_ident`

## Requirements
- R1: After a synchronous active-low reset, `irq` is 0, `ier_q` is 0 and `id_byte` is 0x01 (with `fifo_en` low).
- R2: A cycle with `ier_we` high loads `ier_wdata[3:0]` into `ier_q`, and bits 7..4 of the write data are ignored. Bit 0 enables received data and timeout, bit 1 enables transmit-empty, bit 2 enables line status, and bit 3 enables modem status.
- R3: When enable bit 2 is set and any of `line_status` bits 1..4 (overrun, parity, framing, break, mask 0x1E) is 1, the low nibble is 0x6. This cause outranks all others. Bits 0 and 5..7 never raise this cause.
- R4: When enable bit 0 is set and `rx_timeout` is 1, and no line-status cause is pending, the low nibble is 0xC.
- R5: When enable bit 0 is set and `line_status[0]` (data ready) is 1, a received-data cause exists if `fifo_en` is 0, or if `rx_level >= rx_trigger`. If it wins the priority, the low nibble is 0x4.
- R6: The transmit-empty pending flag is set by a 0-to-1 change of `thr_empty` while enable bit 1 is 1. It is cleared in any cycle in which `thr_empty` is 0. While it is set and enable bit 1 is 1, and no higher cause is pending, the low nibble is 0x2.
- R7: A cycle with `id_read` high while the low nibble shows 0x2 clears the transmit-empty pending flag, so the identification byte no longer shows 0x2 from the next cycle. A read showing any other code leaves the flag unchanged.
- R8: A write that changes enable bit 1 sets the pending flag to (new bit 1 AND `thr_empty`) in the next cycle, regardless of its previous value. A flag that is cleared while enable bit 1 is 0 stays cleared.
- R9: When enable bit 3 is set and any of `modem_status[3:0]` (delta bits) is 1, and no other cause is pending, the low nibble is 0x0. `modem_status[7:4]` has no effect.
- R10: `id_byte[7:6]` is 2'b11 while `fifo_en` is 1 and 2'b00 otherwise. `id_byte[5:4]` is always 0. With no cause pending, the low nibble is 0x1.
- R11: `irq` is 1 in exactly the cycles in which the low nibble of `id_byte` differs from 0x1. It follows the inputs in the same cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ier_we | input | 1 | Write strobe for the enable register |
| ier_wdata | input | 8 | Write data for the enable register |
| ier_q | output | 4 | Current enable bits |
| id_read | input | 1 | Read strobe of the identification byte |
| line_status | input | 8 | Line-status byte (bit 0 data ready, bits 1..4 errors) |
| rx_timeout | input | 1 | Character-timeout pending |
| fifo_en | input | 1 | FIFOs enabled |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_trigger | input | LVL_W | Receive FIFO trigger level |
| thr_empty | input | 1 | Transmit holding register empty |
| modem_status | input | 8 | Modem-status byte (bits 3..0 delta bits) |
| irq | output | 1 | Interrupt request |
| id_byte | output | 8 | Interrupt identification byte |

## Verification
The only internal state is the enable register, the transmit-empty pending flag and the registered previous `thr_empty`. A wrong value in any of them shows at the ports by the next cycle. A wrong enable bit shows in `ier_q` and, once its cause is active, in the identification code. A lost or stuck pending flag shows in the 0x2 code, and in `irq`, in the first cycle where no higher cause masks it. The bench therefore compares all outputs against a behavioural model on every cycle, and mixes reads, enable toggles and holding-register edges so that each hides the flag as rarely as possible.

// File: rtl/uart_irq_pkg.sv
// Package: shared codes, enable-bit positions and source ordering for the
// UART interrupt identification block.
// Assumes: four enable bits, five interrupt sources, 4-bit identification codes.
package uart_irq_pkg;

    localparam int BUS_W   = 8;
    localparam int EN_W    = 4;
    localparam int NUM_SRC = 5;

    // Enable bit positions (decoded by software, so fixed)
    localparam int IE_RXDATA = 0;
    localparam int IE_THRE   = 1;
    localparam int IE_LINE   = 2;
    localparam int IE_MODEM  = 3;

    // Error bits of the line-status byte that raise a line-status cause
    localparam logic [BUS_W-1:0] LINE_ERR_MASK = 8'h1E;
    localparam int LS_DREADY = 0;

    // Value of the two top identification bits while FIFOs are on
    localparam logic [1:0] FIFO_ON_FLAG = 2'b11;

    typedef enum logic [3:0] {
        CODE_MODEM   = 4'h0,
        CODE_NONE    = 4'h1,
        CODE_THRE    = 4'h2,
        CODE_RXDATA  = 4'h4,
        CODE_LINE    = 4'h6,
        CODE_TIMEOUT = 4'hC
    } irq_code_e;

    // Source index = priority rank, 0 is most urgent
    localparam int SRC_LINE    = 0;
    localparam int SRC_TIMEOUT = 1;
    localparam int SRC_RXDATA  = 2;
    localparam int SRC_THRE    = 3;
    localparam int SRC_MODEM   = 4;

    function automatic irq_code_e src_code(input int idx);
        case (idx)
            SRC_LINE:    return CODE_LINE;
            SRC_TIMEOUT: return CODE_TIMEOUT;
            SRC_RXDATA:  return CODE_RXDATA;
            SRC_THRE:    return CODE_THRE;
            SRC_MODEM:   return CODE_MODEM;
            default:     return CODE_NONE;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_enable_reg.sv
// Module: interrupt enable register.
// Stores only the low EN_W bits of a bus write and flags a change of the
// transmit-empty enable bit so the pending tracker can resample.
// Assumes: one write strobe per access, synchronous active-low reset.
module uart_irq_enable_reg
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [BUS_W-1:0] wdata,
    output logic [EN_W-1:0]  en_q,
    output logic             thre_toggle,
    output logic             thre_next
);

    logic [BUS_W-EN_W-1:0] unused_hi;
    assign unused_hi = wdata[BUS_W-1:EN_W];

    // Detect a write that flips the transmit-empty enable
    always_comb begin
        thre_next   = wdata[IE_THRE];
        thre_toggle = we && (wdata[IE_THRE] != en_q[IE_THRE]);
    end

    // Hold the enable bits
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (we)
            en_q <= wdata[EN_W-1:0];
    end

    // R2
    en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> en_q == $past(wdata[EN_W-1:0]));

endmodule

// File: rtl/uart_irq_thre_track.sv
// Module: sticky transmit-empty pending flag.
// Set on a rising holding-empty edge while enabled, dropped while the holding
// register is full, consumed by an identification read that shows it, and
// resampled whenever the enable bit changes.
// Assumes: thr_empty is 1 out of reset.
module uart_irq_thre_track (
    input  logic clk,
    input  logic rst_n,
    input  logic thre_en,
    input  logic en_toggle,
    input  logic en_next,
    input  logic thr_empty,
    input  logic id_read,
    input  logic shown_thre,
    output logic pend_q
);

    logic empty_d;

    // Remember last holding-empty level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n)
            empty_d <= 1'b1;
        else
            empty_d <= thr_empty;
    end

    // Update the pending flag; enable change has the final word
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (en_toggle)
            pend_q <= en_next && thr_empty;
        else if (!thr_empty)
            pend_q <= 1'b0;
        else if (!empty_d && thre_en)
            pend_q <= 1'b1;
        else if (id_read && shown_thre)
            pend_q <= 1'b0;
    end

    // R7
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_read && shown_thre && !en_toggle) |=> !pend_q);

    // R8
    rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_toggle |=> pend_q == ($past(en_next) && $past(thr_empty)));

    // R6
    pend_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !thre_en |-> !pend_q);

endmodule

// File: rtl/uart_irq_prio.sv
// Module: fixed-priority picker.
// Grants the lowest-indexed active request and returns its code, or the
// no-interrupt code when nothing requests.
// Assumes: request index equals priority rank (package ordering).
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] req,
    output irq_code_e          code
);

    logic [NUM_SRC-1:0] grant;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_grant
        if (i == 0) begin : g_top
            assign grant[i] = req[i];
        end else begin : g_rest
            assign grant[i] = req[i] && !(|req[i-1:0]);
        end
    end

    // Translate the single grant into an identification code
    always_comb begin
        code = CODE_NONE;
        for (int i = 0; i < NUM_SRC; i++)
            if (grant[i]) code = src_code(i);
    end

    // R11
    always_comb begin
        one_grant_chk: assert ($onehot0(grant));
    end

endmodule

// File: rtl/uart_irq_ident.sv
// Module: UART interrupt identification and request (top).
// Gathers the five interrupt causes, gates them with the enable bits, picks
// the most urgent and forms the identification byte and the request line.
// Assumes: status inputs are already synchronous to clk; FIFO_DEPTH sets the
// width of the level and trigger inputs.
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ier_we,
    input  logic [BUS_W-1:0] ier_wdata,
    output logic [EN_W-1:0]  ier_q,
    input  logic             id_read,
    input  logic [BUS_W-1:0] line_status,
    input  logic             rx_timeout,
    input  logic             fifo_en,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_trigger,
    input  logic             thr_empty,
    input  logic [BUS_W-1:0] modem_status,
    output logic             irq,
    output logic [BUS_W-1:0] id_byte
);

    logic               thre_toggle, thre_next, thre_pend;
    logic [NUM_SRC-1:0] req;
    irq_code_e          code;
    logic [3:0]         unused_msr_hi;

    assign unused_msr_hi = modem_status[7:4];

    uart_irq_enable_reg u_en (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (ier_we),
        .wdata       (ier_wdata),
        .en_q        (ier_q),
        .thre_toggle (thre_toggle),
        .thre_next   (thre_next)
    );

    uart_irq_thre_track u_thre (
        .clk        (clk),
        .rst_n      (rst_n),
        .thre_en    (ier_q[IE_THRE]),
        .en_toggle  (thre_toggle),
        .en_next    (thre_next),
        .thr_empty  (thr_empty),
        .id_read    (id_read),
        .shown_thre (code == CODE_THRE),
        .pend_q     (thre_pend)
    );

    // Form the gated cause vector in priority order
    always_comb begin
        req              = '0;
        req[SRC_LINE]    = ier_q[IE_LINE] && |(line_status & LINE_ERR_MASK);
        req[SRC_TIMEOUT] = ier_q[IE_RXDATA] && rx_timeout;
        req[SRC_RXDATA]  = ier_q[IE_RXDATA] && line_status[LS_DREADY] &&
                           (!fifo_en || (rx_level >= rx_trigger));
        req[SRC_THRE]    = ier_q[IE_THRE] && thre_pend;
        req[SRC_MODEM]   = ier_q[IE_MODEM] && |modem_status[3:0];
    end

    uart_irq_prio u_prio (
        .req  (req),
        .code (code)
    );

    // Build the identification byte and the request line
    always_comb begin
        id_byte = {(fifo_en ? FIFO_ON_FLAG : 2'b00), 2'b00, code};
        irq     = (code != CODE_NONE);
    end

    // R3
    line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_q[IE_LINE] && |(line_status & LINE_ERR_MASK)) |-> id_byte[3:0] == 4'h6);

    // R9
    modem_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_byte[3:0] == 4'h0) |-> (ier_q[IE_MODEM] && !irq == 1'b0));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq && ier_q == '0));

endmodule

// File: tb/sim_uart_irq_ident.sv
// Bench: behavioural reference model compared on every clock.
module sim_uart_irq_ident;

    localparam int FIFO_DEPTH = 16;
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n;
    logic             ier_we;
    logic [7:0]       ier_wdata;
    logic [3:0]       ier_q;
    logic             id_read;
    logic [7:0]       line_status;
    logic             rx_timeout;
    logic             fifo_en;
    logic [LVL_W-1:0] rx_level;
    logic [LVL_W-1:0] rx_trigger;
    logic             thr_empty;
    logic [7:0]       modem_status;
    logic             irq;
    logic [7:0]       id_byte;

    always #5 clk = ~clk;

    uart_irq_ident #(.FIFO_DEPTH(FIFO_DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .ier_we(ier_we), .ier_wdata(ier_wdata),
        .ier_q(ier_q), .id_read(id_read), .line_status(line_status),
        .rx_timeout(rx_timeout), .fifo_en(fifo_en), .rx_level(rx_level),
        .rx_trigger(rx_trigger), .thr_empty(thr_empty),
        .modem_status(modem_status), .irq(irq), .id_byte(id_byte)
    );

    int    vectors = 0;
    int    fails   = 0;
    bit    done    = 0;
    string ph      = "";

    // reference model state
    int m_ier;
    bit m_pend;
    bit m_prev;

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_code();
        if ((m_ier & 4) != 0 && (line_status & 8'h1E) != 0) return 6;
        if ((m_ier & 1) != 0 && rx_timeout) return 12;
        if ((m_ier & 1) != 0 && line_status[0] &&
            (!fifo_en || int'(rx_level) >= int'(rx_trigger))) return 4;
        if ((m_ier & 2) != 0 && m_pend) return 2;
        if ((m_ier & 8) != 0 && modem_status[3:0] != 0) return 0;
        return 1;
    endfunction

    function automatic string code_tag(input int c);
        case (c)
            6: return "R3";
            12: return "R4";
            4: return "R5";
            2: return "R6";
            0: return "R9";
            default: return "R10";
        endcase
    endfunction

    // one cycle: drive at negedge, compare, advance model to post-edge state
    task automatic cyc(input bit we, input int wd, input bit rd,
                       input int ls, input int ms, input bit te, input bit to,
                       input bit fe, input int lvl, input int trg);
        int  c;
        bit  tog;
        ier_we = we; ier_wdata = 8'(wd); id_read = rd;
        line_status = 8'(ls); modem_status = 8'(ms); thr_empty = te;
        rx_timeout = to; fifo_en = fe;
        rx_level = LVL_W'(lvl); rx_trigger = LVL_W'(trg);
        #1;
        c = exp_code();
        chk("R2", int'(ier_q), m_ier);
        chk((ph != "") ? ph : code_tag(c), int'(id_byte[3:0]), c);
        chk("R10", int'(id_byte[7:4]), fe ? 12 : 0);
        chk("R11", int'(irq), (c != 1) ? 1 : 0);
        tog = we && (((wd >> 1) & 1) != ((m_ier >> 1) & 1));
        if (tog) m_pend = ((wd & 2) != 0) && te;
        else if (!te) m_pend = 0;
        else if (!m_prev && (m_ier & 2) != 0) m_pend = 1;
        else if (rd && c == 2) m_pend = 0;
        m_prev = te;
        if (we) m_ier = wd & 15;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; ier_we = 0; ier_wdata = 0; id_read = 0; line_status = 0;
        modem_status = 0; thr_empty = 1; rx_timeout = 0; fifo_en = 0;
        rx_level = 0; rx_trigger = 0;
        m_ier = 0; m_pend = 0; m_prev = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        ph = "R1";
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
        chk("R1", int'(id_byte), 1);
        // R2 upper write bits ignored
        ph = "R2";
        cyc(1, 8'hF0, 0, 0, 0, 1, 0, 0, 0, 0);
        cyc(1, 8'hA5, 0, 0, 0, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
        // R3 line status outranks data; bit 5 is not an error
        ph = "R3";
        cyc(0, 0, 0, 8'h03, 0, 1, 1, 0, 0, 0);
        cyc(0, 0, 0, 8'h21, 0, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 8'h11, 0, 1, 0, 0, 0, 0);
        // R4 timeout over data
        ph = "R4";
        cyc(1, 1, 0, 8'h01, 0, 1, 1, 1, 1, 8);
        cyc(0, 0, 0, 8'h01, 0, 1, 1, 1, 1, 8);
        // R5 trigger qualification
        ph = "R5";
        cyc(0, 0, 0, 8'h01, 0, 1, 0, 1, 3, 4);
        cyc(0, 0, 0, 8'h01, 0, 1, 0, 1, 4, 4);
        cyc(0, 0, 0, 8'h01, 0, 1, 0, 0, 0, 14);
        // R6 transmit-empty set on edge
        ph = "R6";
        cyc(1, 2, 0, 0, 0, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
        // R7 read consumes it
        ph = "R7";
        cyc(0, 0, 1, 0, 0, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
        // R8 enable toggle rearms
        ph = "R8";
        cyc(1, 0, 0, 0, 0, 1, 0, 0, 0, 0);
        cyc(1, 2, 0, 0, 0, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
        // R9 modem deltas only in low nibble
        ph = "R9";
        cyc(1, 8, 0, 0, 8'hF0, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 8'h04, 1, 0, 0, 0, 0);
        // random mix
        ph = "";
        for (int i = 0; i < 4000; i++) begin
            cyc(($urandom % 8) == 0, int'($urandom % 256), ($urandom % 4) == 0,
                ((($urandom % 6) == 0) ? int'($urandom % 256) : int'($urandom % 2)),
                ((($urandom % 5) == 0) ? int'($urandom % 256) : 0),
                ($urandom % 5) != 0, ($urandom % 7) == 0, ($urandom % 2) == 0,
                int'($urandom % 17), int'($urandom % 17));
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule